// File: doc/BRIEF.md
# Reset Sequencer with Boot Strap Capture

This block turns an asynchronous, active-low external reset request into the chip's reset sequence. While the request is held, the reset-out pin is driven low and the internal core reset is held. The bus-float enable is raised so the pad logic puts the address, data, size, read/write, address-strobe and transfer-start outputs into high impedance. After the request is removed, the release passes through a synchronizer. The block then waits for the PLL lock indication, negates reset-out, and lets the core leave reset one cycle later.

During reset the block also records the boot configuration. When the configuration-from-pins strap is high, the configuration word is taken from the sampled external data bus; otherwise a fixed default word is used. A two-bit clock-mode strap is recorded in the same way. Both values track the pins on every clock while reset-out is low. They are frozen by the clock edge on which reset-out negates, and they keep that value until the next external reset.

The sequence is driven by four named states:
- `ST_HOLD`: the request is active, or its release has not yet left the synchronizer.
- `ST_RELOCK`: the release is seen and the block waits for PLL lock.
- `ST_RELEASE`: reset-out is negated and core reset is still held.
- `ST_RUN`: normal operation.

The state transitions are:
- `ST_HOLD`→`ST_RELOCK` when the synchronized request is released.
- `ST_RELOCK`→`ST_RELEASE` on a clock where lock is high.
- `ST_RELEASE`→`ST_RUN` unconditionally.
- Any state →`ST_HOLD` when a new request arrives. This happens asynchronously, and also through the synchronized level.

Top module: `boot_reset_seq`

## Requirements
- R1: While `ext_rst_req_n_i` is low, `rst_out_n_o` is 0, `core_rst_o` is 1 and `bus_float_o` is 1, with no clock edge needed.
- R2: The release of `ext_rst_req_n_i` passes a two-flop synchronizer. With lock already high, `rst_out_n_o` stays 0 after the first three rising edges that follow the release, and becomes 1 after the fourth.
- R3: After the synchronized release, `rst_out_n_o` stays 0 for as long as `pll_locked_i` is 0. It becomes 1 after the first rising edge at which `pll_locked_i` is sampled 1.
- R4: `core_rst_o` and `bus_float_o` stay 1 on the cycle on which `rst_out_n_o` rises. Both become 0 exactly one rising edge later.
- R5: While `rst_out_n_o` is 0, each rising edge loads `boot_cfg_o` and `clk_mode_o`. `boot_cfg_o` gets `pin_data_i` if `cfg_from_pins_i` is 1, and the default word otherwise. `clk_mode_o` gets `clk_mode_strap_i`.
- R6: The values loaded at the edge where `rst_out_n_o` rises are kept unchanged while `rst_out_n_o` stays 1, whatever the pins do.
- R7: The default configuration word is the parameter `DEFAULT_CFG`, which is 16'hA5C3 by default. It is used whenever `cfg_from_pins_i` is 0.
- R8: A new request during the lock wait restarts the sequence. After the new release, `rst_out_n_o` again stays 0 for three edges even with lock high, and rises after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| ext_rst_req_n_i | input | 1 | External reset request, active low, asynchronous |
| pll_locked_i | input | 1 | PLL lock indication, synchronous to clk_i |
| cfg_from_pins_i | input | 1 | Strap: 1 takes the configuration from the data pins |
| clk_mode_strap_i | input | CMODE_W | Clock-mode strap pins |
| pin_data_i | input | CFG_W | Sampled external data bus |
| rst_out_n_o | output | 1 | Reset-out to external devices, active low |
| core_rst_o | output | 1 | Internal reset, active high |
| bus_float_o | output | 1 | Three-state enable for the bus outputs |
| boot_cfg_o | output | CFG_W | Captured configuration word |
| clk_mode_o | output | CMODE_W | Captured clock mode |

## Verification
Consider a sequencer that leaves `ST_HOLD` too early, or skips the lock wait. It shows as `rst_out_n_o` rising before the fourth edge after release, or while lock is low. This is seen within a single cycle of the expected release point. A wrong transition out of `ST_RELEASE` shows at once in the one-cycle gap between `rst_out_n_o` and `core_rst_o`. A capture that keeps loading after release shows at the configuration outputs on the first clock after the pins change. The bench changes the pins right after the release edge so that this fault becomes visible.

// File: rtl/boot_reset_pkg.sv
package boot_reset_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_RELOCK  = 2'd1,
        ST_RELEASE = 2'd2,
        ST_RUN     = 2'd3
    } seq_state_e;

endpackage

// File: rtl/boot_reset_sync.sv
module boot_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_n_i,
    output logic sync_n_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge arst_n_i) begin
                if (!arst_n_i) chain_q <= 1'b0;
                else           chain_q <= 1'b1;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i or negedge arst_n_i) begin
                if (!arst_n_i) chain_q <= '0;
                else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign sync_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/boot_reset_fsm.sv
module boot_reset_fsm
    import boot_reset_pkg::*;
(
    input  logic clk_i,
    input  logic arst_n_i,
    input  logic sync_rel_i,
    input  logic lock_i,
    output logic rst_out_n_o,
    output logic core_rst_o,
    output logic bus_float_o,
    output logic cap_load_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    // state register
    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) state_q <= ST_HOLD;
        else           state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (sync_rel_i) state_d = ST_RELOCK;
            end
            ST_RELOCK: begin
                if (!sync_rel_i)  state_d = ST_HOLD;
                else if (lock_i)  state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!sync_rel_i) state_d = ST_HOLD;
                else             state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!sync_rel_i) state_d = ST_HOLD;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        rst_out_n_o = 1'b0;
        core_rst_o  = 1'b1;
        bus_float_o = 1'b1;
        cap_load_o  = 1'b1;
        unique case (state_q)
            ST_HOLD, ST_RELOCK: begin
                rst_out_n_o = 1'b0;
                core_rst_o  = 1'b1;
                bus_float_o = 1'b1;
                cap_load_o  = 1'b1;
            end
            ST_RELEASE: begin
                rst_out_n_o = 1'b1;
                core_rst_o  = 1'b1;
                bus_float_o = 1'b1;
                cap_load_o  = 1'b0;
            end
            ST_RUN: begin
                rst_out_n_o = 1'b1;
                core_rst_o  = 1'b0;
                bus_float_o = 1'b0;
                cap_load_o  = 1'b0;
            end
            default: begin
                rst_out_n_o = 1'b0;
                core_rst_o  = 1'b1;
                bus_float_o = 1'b1;
                cap_load_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/boot_reset_capture.sv
module boot_reset_capture #(
    parameter int              CFG_W       = 16,
    parameter int              CMODE_W     = 2,
    parameter logic [CFG_W-1:0] DEFAULT_CFG = 16'hA5C3
) (
    input  logic               clk_i,
    input  logic               load_i,
    input  logic               from_pins_i,
    input  logic [CFG_W-1:0]   pins_i,
    input  logic [CMODE_W-1:0] mode_i,
    output logic [CFG_W-1:0]   cfg_o,
    output logic [CMODE_W-1:0] mode_o
);

    logic [CFG_W-1:0]   cfg_q;
    logic [CMODE_W-1:0] mode_q;
    logic [CFG_W-1:0]   cfg_sel;

    // per-bit source choice between pins and default
    generate
        for (genvar b = 0; b < CFG_W; b++) begin : g_bit
            assign cfg_sel[b] = from_pins_i ? pins_i[b] : DEFAULT_CFG[b];
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (load_i) begin
            cfg_q  <= cfg_sel;
            mode_q <= mode_i;
        end
    end

    assign cfg_o  = cfg_q;
    assign mode_o = mode_q;

endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq #(
    parameter int               CFG_W       = 16,
    parameter int               CMODE_W     = 2,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CFG_W-1:0] DEFAULT_CFG = 16'hA5C3
) (
    input  logic               clk_i,
    input  logic               ext_rst_req_n_i,
    input  logic               pll_locked_i,
    input  logic               cfg_from_pins_i,
    input  logic [CMODE_W-1:0] clk_mode_strap_i,
    input  logic [CFG_W-1:0]   pin_data_i,
    output logic               rst_out_n_o,
    output logic               core_rst_o,
    output logic               bus_float_o,
    output logic [CFG_W-1:0]   boot_cfg_o,
    output logic [CMODE_W-1:0] clk_mode_o
);

    logic sync_rel;
    logic cap_load;

    boot_reset_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i    (clk_i),
        .arst_n_i (ext_rst_req_n_i),
        .sync_n_o (sync_rel)
    );

    boot_reset_fsm fsm_i (
        .clk_i       (clk_i),
        .arst_n_i    (ext_rst_req_n_i),
        .sync_rel_i  (sync_rel),
        .lock_i      (pll_locked_i),
        .rst_out_n_o (rst_out_n_o),
        .core_rst_o  (core_rst_o),
        .bus_float_o (bus_float_o),
        .cap_load_o  (cap_load)
    );

    boot_reset_capture #(
        .CFG_W       (CFG_W),
        .CMODE_W     (CMODE_W),
        .DEFAULT_CFG (DEFAULT_CFG)
    ) cap_i (
        .clk_i       (clk_i),
        .load_i      (cap_load),
        .from_pins_i (cfg_from_pins_i),
        .pins_i      (pin_data_i),
        .mode_i      (clk_mode_strap_i),
        .cfg_o       (boot_cfg_o),
        .mode_o      (clk_mode_o)
    );

endmodule

// File: rtl/boot_reset_chk.sv
module boot_reset_chk #(
    parameter int CFG_W   = 16,
    parameter int CMODE_W = 2
) (
    input logic               clk_i,
    input logic               ext_rst_req_n_i,
    input logic               pll_locked_i,
    input logic               rst_out_n_o,
    input logic               core_rst_o,
    input logic               bus_float_o,
    input logic [CFG_W-1:0]   boot_cfg_o,
    input logic [CMODE_W-1:0] clk_mode_o
);

    AST_RELEASE_SYNCED: assert property (@(posedge clk_i) disable iff (!ext_rst_req_n_i)
        $rose(rst_out_n_o) |-> $past(ext_rst_req_n_i, 3)); // R2

    AST_LOCK_GATES_RELEASE: assert property (@(posedge clk_i) disable iff (!ext_rst_req_n_i)
        $rose(rst_out_n_o) |-> $past(pll_locked_i)); // R3

    AST_CORE_HELD_AT_RISE: assert property (@(posedge clk_i) disable iff (!ext_rst_req_n_i)
        $rose(rst_out_n_o) |-> (core_rst_o && bus_float_o)); // R4

    AST_CORE_LAGS_ONE: assert property (@(posedge clk_i) disable iff (!ext_rst_req_n_i)
        $rose(rst_out_n_o) |=> (!core_rst_o && !bus_float_o)); // R4

    AST_CORE_NEEDS_RSTOUT: assert property (@(posedge clk_i) disable iff (!ext_rst_req_n_i)
        !core_rst_o |-> rst_out_n_o); // R4

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!ext_rst_req_n_i)
        (rst_out_n_o && $past(rst_out_n_o)) |-> ($stable(boot_cfg_o) && $stable(clk_mode_o))); // R6

endmodule

bind boot_reset_seq boot_reset_chk #(
    .CFG_W   (CFG_W),
    .CMODE_W (CMODE_W)
) chk_i (
    .clk_i           (clk_i),
    .ext_rst_req_n_i (ext_rst_req_n_i),
    .pll_locked_i    (pll_locked_i),
    .rst_out_n_o     (rst_out_n_o),
    .core_rst_o      (core_rst_o),
    .bus_float_o     (bus_float_o),
    .boot_cfg_o      (boot_cfg_o),
    .clk_mode_o      (clk_mode_o)
);

// File: tb/boot_reset_seq_tb.sv
module boot_reset_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CFG_W      = 16;
    localparam int CMODE_W    = 2;
    localparam logic [CFG_W-1:0] DEF_CFG = 16'hA5C3;
    localparam int NVEC = 6;

    localparam logic             VEC_EN   [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [CFG_W-1:0] VEC_DATA [NVEC] = '{16'h1234, 16'hFFFF, 16'h0000,
                                                     16'h0000, 16'hFFFF, 16'h5A3C};
    localparam logic [CMODE_W-1:0] VEC_CM [NVEC] = '{2'b00, 2'b11, 2'b01, 2'b10, 2'b11, 2'b10};

    logic               clk = 1'b0;
    logic               ext_rst_n;
    logic               lock;
    logic               from_pins;
    logic [CMODE_W-1:0] cm;
    logic [CFG_W-1:0]   data;
    logic               rst_out_n;
    logic               core_rst;
    logic               bus_float;
    logic [CFG_W-1:0]   cfg;
    logic [CMODE_W-1:0] cmode;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_reset_seq #(.CFG_W(CFG_W), .CMODE_W(CMODE_W)) dut_i (
        .clk_i            (clk),
        .ext_rst_req_n_i  (ext_rst_n),
        .pll_locked_i     (lock),
        .cfg_from_pins_i  (from_pins),
        .clk_mode_strap_i (cm),
        .pin_data_i       (data),
        .rst_out_n_o      (rst_out_n),
        .core_rst_o       (core_rst),
        .bus_float_o      (bus_float),
        .boot_cfg_o       (cfg),
        .clk_mode_o       (cmode)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_held(input string req, input string when);
        check(req, {when, " rst_out_n"}, {31'd0, rst_out_n}, 32'd0);
        check(req, {when, " core_rst"},  {31'd0, core_rst},  32'd1);
        check(req, {when, " bus_float"}, {31'd0, bus_float}, 32'd1);
    endtask

    // Full boot: assert request, tick, release with lock high, walk to run.
    task automatic boot_vec(input logic en, input logic [CFG_W-1:0] d,
                            input logic [CMODE_W-1:0] m);
        logic [CFG_W-1:0] exp_cfg;
        exp_cfg   = en ? d : DEF_CFG;
        ext_rst_n = 1'b0;
        lock      = 1'b0;
        from_pins = en;
        data      = d;
        cm        = m;
        #1;
        check_held("R1", "vec request");
        tick();
        tick();
        check("R5", "follow cfg", {16'd0, cfg}, {16'd0, exp_cfg});
        check("R5", "follow mode", {30'd0, cmode}, {30'd0, m});
        if (!en) check("R7", "default word", {16'd0, cfg}, {16'd0, DEF_CFG});
        ext_rst_n = 1'b1;
        lock      = 1'b1;
        tick();
        tick();
        tick();
        check("R2", "vec edge3 rst_out_n", {31'd0, rst_out_n}, 32'd0);
        tick();
        check("R2", "vec edge4 rst_out_n", {31'd0, rst_out_n}, 32'd1);
        check("R4", "vec core held at release", {31'd0, core_rst}, 32'd1);
        // disturb straps after the latch edge
        from_pins = ~en;
        data      = ~d;
        cm        = ~m;
        tick();
        check("R4", "vec core released", {31'd0, core_rst}, 32'd0);
        check("R4", "vec bus unfloated", {31'd0, bus_float}, 32'd0);
        check("R6", "vec cfg frozen", {16'd0, cfg}, {16'd0, exp_cfg});
        check("R6", "vec mode frozen", {30'd0, cmode}, {30'd0, m});
        repeat (3) tick();
        check("R6", "vec cfg still frozen", {16'd0, cfg}, {16'd0, exp_cfg});
    endtask

    initial begin
        ext_rst_n = 1'b0;
        lock      = 1'b0;
        from_pins = 1'b1;
        cm        = 2'b01;
        data      = 16'hC0DE;
        #1;
        // reset state
        check_held("R1", "power-up");
        tick();
        tick();
        check("R5", "reset follow cfg", {16'd0, cfg}, 32'h0000C0DE);
        data = 16'hBEEF;
        tick();
        check("R5", "reset follow new cfg", {16'd0, cfg}, 32'h0000BEEF);
        from_pins = 1'b0;
        tick();
        check("R7", "default while strap low", {16'd0, cfg}, {16'd0, DEF_CFG});

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            boot_vec(VEC_EN[i], VEC_DATA[i], VEC_CM[i]);
        end

        // R1: asynchronous assertion from run state
        #2;
        ext_rst_n = 1'b0;
        #1;
        check_held("R1", "async from run");

        // R3: lock wait
        from_pins = 1'b1;
        data      = 16'h0F0F;
        cm        = 2'b10;
        tick();
        ext_rst_n = 1'b1;
        lock      = 1'b0;
        for (int k = 0; k < 12; k++) begin
            tick();
            check("R3", "rst_out_n while unlocked", {31'd0, rst_out_n}, 32'd0);
        end
        data = 16'h7E57;
        lock = 1'b1;
        tick();
        check("R3", "rst_out_n after lock", {31'd0, rst_out_n}, 32'd1);
        check("R6", "latched at lock edge", {16'd0, cfg}, 32'h00007E57);
        lock = 1'b0;
        tick();
        check("R4", "core released after lock", {31'd0, core_rst}, 32'd0);

        // R8: restart during relock wait
        ext_rst_n = 1'b0;
        tick();
        ext_rst_n = 1'b1;
        lock      = 1'b0;
        repeat (5) tick();
        check("R8", "waiting before restart", {31'd0, rst_out_n}, 32'd0);
        ext_rst_n = 1'b0;
        #1;
        check_held("R8", "restart request");
        tick();
        ext_rst_n = 1'b1;
        lock      = 1'b1;
        tick();
        tick();
        tick();
        check("R8", "restart edge3 rst_out_n", {31'd0, rst_out_n}, 32'd0);
        tick();
        check("R8", "restart edge4 rst_out_n", {31'd0, rst_out_n}, 32'd1);
        tick();
        check("R8", "restart core released", {31'd0, core_rst}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule